// File: doc/BRIEF.md
# Programmable Read Latency Pipeline

This block tells a memory read path when the first beat of read data is due after a read command. Time is counted in half-clock slots, so a burst can begin on a rising clock edge or on a falling one. A mode-register load sets the latency. The load carries a three-bit latency code in bits 6:4 of the mode word. Code 010 selects 2 clocks (4 slots), 110 selects 2.5 clocks (5 slots) and 011 selects 3 clocks (6 slots). A load with any other code is rejected.

For each read command sampled on a rising edge, the block marks `BURST_LEN` consecutive half-cycle slots as data-valid, starting at the latency slot. A valid slot that falls on a rising edge is shown on `valid_rise`. A valid slot that falls on a falling edge is shown on `valid_fall`. Both outputs refer to the clock period that starts at the rising edge that registers them. Commands spaced `BURST_LEN/2` clocks apart join into one window with no gap.

The outputs carry no ready signal and cannot be held back. The memory delivers data whether or not the consumer is waiting, so the receiver must take every marked beat. Bits 12:7 of the mode word are the operating-mode field. All zeros is normal operation. Bit 8 alone requests a DLL reset, which appears as a one-cycle pulse.

Top module: `rdlat_pipe`

## Requirements
- R1: After reset, `valid_rise`, `valid_fall`, `dll_rst_pulse` and `cfg_err` are low, and the latency is 2 clocks (code 010).
- R2: With code 010 loaded, a read sampled at rising edge n gives its first beat on `valid_rise` in the clock period that starts at edge n+2.
- R3: With code 011 loaded, the first beat appears on `valid_rise` in the period that starts at edge n+3.
- R4: With code 110 loaded, the first beat appears on `valid_fall` in the period that starts at edge n+2. `valid_rise` is low in that period when no other burst is active.
- R5: One read marks exactly `BURST_LEN` consecutive half-cycle slots as valid, starting at its latency slot.
- R6: Reads spaced exactly `BURST_LEN/2` clocks apart produce one continuous run of valid slots with no gap, for every latency.
- R7: A load whose latency code (bits 6:4) is not 010, 011 or 110 sets `cfg_err` from the next cycle on. The latency in use does not change.
- R8: Operating-mode bits 12:7 must be 000000 (normal) or 000010 (bit 8 only, DLL reset). An accepted load with bit 8 set raises `dll_rst_pulse` for exactly the one cycle after the load. Any other operating-mode pattern rejects the load as in R7, with no pulse.
- R9: An accepted load clears `cfg_err`.
- R10: A read sampled on the same edge as a load uses the latency that was in force before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Strobe: apply `mode_word` at this edge |
| mode_word | input | MODE_W | Mode word: bits 12:7 operating mode, bits 6:4 latency code |
| rd_cmd | input | 1 | Read command strobe |
| valid_rise | output | 1 | Data beat due at this period's rising edge |
| valid_fall | output | 1 | Data beat due at this period's falling edge |
| dll_rst_pulse | output | 1 | One-cycle DLL reset request |
| cfg_err | output | 1 | Last load was rejected |

## Verification
A read sampled at edge n puts its first beat in the period after edge n+2 (4 or 5 slots) or after edge n+3 (6 slots). `dll_rst_pulse` and `cfg_err` are valid in the period after the loading edge. The bench drives each stimulus just after a rising edge and reads the outputs 1 ns after the next edge. It stores two slots per period into a window indexed from the command edge, so each slot has an expected value worked out from the latency and the burst length. The bound checker covers the same due cycles with fixed `$past` depths of three and four.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
  // Field positions in the mode word
  localparam int LAT_LSB   = 4;
  localparam int LAT_W     = 3;
  localparam int OPM_LSB   = 7;
  localparam int DLLR_BIT  = 8;
  localparam int SLOT_W    = 3;
  localparam int MAX_SLOTS = 6;

  typedef enum logic [LAT_W-1:0] {
    CL_TWO      = 3'b010,
    CL_THREE    = 3'b011,
    CL_TWO_HALF = 3'b110
  } cl_code_e;

  function automatic logic cl_legal(input logic [LAT_W-1:0] code);
    return (code == CL_TWO) || (code == CL_THREE) || (code == CL_TWO_HALF);
  endfunction

  function automatic logic [SLOT_W-1:0] cl_to_slots(input logic [LAT_W-1:0] code);
    logic [SLOT_W-1:0] s;
    case (code)
      CL_THREE:    s = 3'd6;
      CL_TWO_HALF: s = 3'd5;
      default:     s = 3'd4;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rdlat_mode_dec.sv
module rdlat_mode_dec
  import rdlat_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output logic [SLOT_W-1:0] lat_slots,
  output logic              dll_pulse,
  output logic              cfg_err
);
  localparam int OPM_W = MODE_W - OPM_LSB;
  localparam logic [OPM_W-1:0] OPM_DLL = OPM_W'(1) << (DLLR_BIT - OPM_LSB);

  logic [LAT_W-1:0] code;
  logic [OPM_W-1:0] opm;
  logic             op_ok;
  logic             accept;

  always_comb begin
    code   = word[LAT_LSB +: LAT_W];
    opm    = word[MODE_W-1:OPM_LSB];
    op_ok  = (opm == '0) || (opm == OPM_DLL);
    accept = load && op_ok && cl_legal(code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_slots <= 3'd4;
      dll_pulse <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      dll_pulse <= accept && (opm == OPM_DLL);
      if (load) cfg_err <= !accept;
      if (accept) lat_slots <= cl_to_slots(code);
    end
  end
endmodule

// File: rtl/rdlat_slot_sched.sv
module rdlat_slot_sched
  import rdlat_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd,
  input  logic [SLOT_W-1:0] lat_slots,
  output logic              rise,
  output logic              fall
);
  // Bit j marks slot j counted from the rising edge of the current period
  localparam int WIN_W = MAX_SLOTS + BURST_LEN;

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] burst_mask;
  logic [WIN_W-1:0] win_d;

  always_comb begin
    burst_mask = {{(WIN_W-BURST_LEN){1'b0}}, {BURST_LEN{1'b1}}} << lat_slots;
    win_d      = (win_q >> 2) | (cmd ? burst_mask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign rise = win_q[0];
  assign fall = win_q[1];
endmodule

// File: rtl/rdlat_pipe.sv
module rdlat_pipe
  import rdlat_pkg::*;
#(
  parameter int MODE_W    = 13,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              rd_cmd,
  output logic              valid_rise,
  output logic              valid_fall,
  output logic              dll_rst_pulse,
  output logic              cfg_err
);
  logic [SLOT_W-1:0] lat_slots;

  rdlat_mode_dec #(.MODE_W(MODE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word),
    .lat_slots(lat_slots), .dll_pulse(dll_rst_pulse), .cfg_err(cfg_err)
  );

  rdlat_slot_sched #(.BURST_LEN(BURST_LEN)) u_sched (
    .clk(clk), .rst_n(rst_n), .cmd(rd_cmd), .lat_slots(lat_slots),
    .rise(valid_rise), .fall(valid_fall)
  );
endmodule

// File: rtl/rdlat_pipe_chk.sv
module rdlat_pipe_chk
  import rdlat_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_load,
  input logic [MODE_W-1:0] mode_word,
  input logic              rd_cmd,
  input logic              valid_rise,
  input logic              valid_fall,
  input logic              dll_rst_pulse,
  input logic              cfg_err,
  input logic [SLOT_W-1:0] lat_slots
);
  // R2
  lat_two_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_cmd, 3) && ($past(lat_slots, 3) == 3'd4)) |-> valid_rise);

  // R3
  lat_three_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_cmd, 4) && ($past(lat_slots, 4) == 3'd6)) |-> valid_rise);

  // R4
  lat_half_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_cmd, 3) && ($past(lat_slots, 3) == 3'd5)) |-> valid_fall);

  // R7
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && !cl_legal(mode_word[LAT_LSB +: LAT_W])) |=> (cfg_err && $stable(lat_slots)));

  // R8
  dll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst_pulse |=> !dll_rst_pulse);

  // R8
  dll_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst_pulse |-> $past(mode_load));
endmodule

bind rdlat_pipe rdlat_pipe_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
  .rd_cmd(rd_cmd), .valid_rise(valid_rise), .valid_fall(valid_fall),
  .dll_rst_pulse(dll_rst_pulse), .cfg_err(cfg_err), .lat_slots(lat_slots)
);

// File: tb/test_rdlat_pipe.sv
module test_rdlat_pipe;
  localparam int MW = 13;
  localparam int BL = 8;
  localparam int NC = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_load = 1'b0;
  logic [MW-1:0] mode_word = '0;
  logic          rd_cmd = 1'b0;
  logic          valid_rise, valid_fall, dll_rst_pulse, cfg_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rdlat_pipe #(.MODE_W(MW), .BURST_LEN(BL)) i_rdlat_pipe (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .rd_cmd(rd_cmd), .valid_rise(valid_rise), .valid_fall(valid_fall),
    .dll_rst_pulse(dll_rst_pulse), .cfg_err(cfg_err)
  );

  function automatic logic [MW-1:0] mw(input logic [2:0] code, input logic [5:0] opm);
    return {opm, code, 4'b0000};
  endfunction

  function automatic logic [63:0] expect_win(input int slots, input int gap, input int ncmd);
    logic [63:0] e = '0;
    for (int i = 0; i < ncmd; i++)
      for (int b = 0; b < BL; b++) e[2*i*gap + slots + b] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_window(input int gap, input int ncmd, input logic ld,
                            input logic [MW-1:0] w, output logic [63:0] obs);
    obs = '0;
    for (int c = 0; c < NC; c++) begin
      rd_cmd    = ((c % gap) == 0) && ((c / gap) < ncmd);
      mode_load = ld && (c == 0);
      if (c == 0) mode_word = w;
      @(posedge clk); #1;
      rd_cmd = 1'b0; mode_load = 1'b0;
      obs[2*c]   = valid_rise;
      obs[2*c+1] = valid_fall;
    end
  endtask

  task automatic load(input string req, input logic [MW-1:0] w,
                      input logic exp_dll, input logic exp_err);
    mode_load = 1'b1; mode_word = w;
    @(posedge clk); #1;
    mode_load = 1'b0;
    check(req, {62'd0, dll_rst_pulse, cfg_err}, {62'd0, exp_dll, exp_err});
    @(posedge clk); #1;
    check(req, {63'd0, dll_rst_pulse}, 64'd0);
  endtask

  task automatic single_read(input string req, input int slots);
    logic [63:0] obs;
    run_window(4, 1, 1'b0, '0, obs);
    check(req, obs, expect_win(slots, 4, 1));
    check("R5 beat count", 64'($countones(obs)), 64'(BL));
  endtask

  task automatic t_reset;
    // R1
    check("R1 outputs", {60'd0, valid_rise, valid_fall, dll_rst_pulse, cfg_err}, 64'd0);
    single_read("R1 default latency", 4);
  endtask

  task automatic t_latencies;
    load("R2 load", mw(3'b010, 6'd0), 1'b0, 1'b0);
    single_read("R2 first beat", 4);
    load("R3 load", mw(3'b011, 6'd0), 1'b0, 1'b0);
    single_read("R3 first beat", 6);
    load("R4 load", mw(3'b110, 6'd0), 1'b0, 1'b0);
    single_read("R4 falling start", 5);
  endtask

  task automatic t_seamless;
    logic [63:0] obs;
    logic [2:0]  codes [3] = '{3'b010, 3'b110, 3'b011};
    int          slots [3] = '{4, 5, 6};
    for (int k = 0; k < 3; k++) begin
      load("R6 load", mw(codes[k], 6'd0), 1'b0, 1'b0);
      run_window(BL/2, 3, 1'b0, '0, obs);
      check("R6 seamless window", obs, expect_win(slots[k], BL/2, 3));
      check("R6 contiguous", obs, ((64'd1 << (3*BL)) - 1) << slots[k]);
    end
  endtask

  task automatic t_reserved;
    load("R7 setup", mw(3'b110, 6'd0), 1'b0, 1'b0);
    load("R7 code 101", mw(3'b101, 6'd0), 1'b0, 1'b1);
    single_read("R7 latency kept", 5);
    load("R7 code 000", mw(3'b000, 6'd0), 1'b0, 1'b1);
    single_read("R7 latency kept", 5);
    load("R9 clear", mw(3'b011, 6'd0), 1'b0, 1'b0);
    single_read("R9 new latency", 6);
  endtask

  task automatic t_dll;
    load("R8 dll reset", mw(3'b010, 6'b000010), 1'b1, 1'b0);
    single_read("R8 latency applied", 4);
    load("R8 bad opmode", mw(3'b011, 6'b000100), 1'b0, 1'b1);
    load("R8 bad opmode", mw(3'b110, 6'b000011), 1'b0, 1'b1);
    single_read("R8 latency kept", 4);
  endtask

  task automatic t_same_edge;
    logic [63:0] obs;
    load("R10 setup", mw(3'b011, 6'd0), 1'b0, 1'b0);
    run_window(4, 1, 1'b1, mw(3'b010, 6'd0), obs);
    check("R10 old latency", obs, expect_win(6, 4, 1));
    single_read("R10 new latency", 4);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_latencies();
    t_seamless();
    t_reserved();
    t_dll();
    t_same_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule